// File: doc/BRIEF.md
# Jump Target Register Unit

This unit sits in an instruction front end and keeps a single dedicated jump-target register, plus a validity flag and an outstanding-update flag. Software fills the register ahead of time. It can load one immediate directly, or choose between two immediates using a condition operand. Later, a jump-to-target operation sends fetch to that address. Because the destination is known before the jump arrives, the jump never needs to be predicted.

Set operations are executed in the back end. The decoder marks a set as outstanding when it sees one. The back end then delivers the operands on a write port. While an update is outstanding, a jump-to-target is held with a stall output until the write lands. Any jump of any kind consumes the stored target and leaves it invalid. A jump-to-target through an invalid register raises a trap instead of redirecting fetch. The target and its validity can be read out continuously and loaded back, so that context switches can preserve them.

Top module: `jump_target_unit`

## Requirements
- R1: After reset the target is invalid (`saveValid` = 0), and `redirect`, `trap` and `stall` are all 0.
- R2: A write with `wrCondMode` = 0 loads `wrImm0` into the target and marks it valid from the next cycle.
- R3: A write with `wrCondMode` = 1 loads `wrImm0` when `wrCond` is zero and `wrImm1` for any nonzero `wrCond`, and marks the target valid.
- R4: `jmpReq` with a valid target and no outstanding update raises `redirect` in that same cycle, with `redirectAddr` equal to the stored target. The target is invalid from the next cycle.
- R5: `jmpReq` with an invalid target and no outstanding update raises `trap` and does not raise `redirect`.
- R6: `otherJump` (any jump not taken through this register) leaves the target invalid from the next cycle.
- R7: `setIssue` marks an update outstanding. While it is outstanding, `jmpReq` gives `stall` = 1, with no redirect and no trap, and the stored state is held. After the write lands, the next cycle redirects to the newly written address.
- R8: `saveTarget` and `saveValid` always show the stored state. `restoreEn` loads `restoreTarget` and `restoreValid` from the next cycle.
- R9: At most one of `redirect`, `trap` and `stall` is high in any cycle.
- R10: When a write and a completed jump share a cycle, the jump uses the old target. The new value is stored, but it is left invalid.
- R11: `restoreEn` overrides a write in the same cycle, and it clears any outstanding update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setIssue | input | 1 | Decoder saw a set operation; update now outstanding |
| wrValid | input | 1 | Back end delivers set operands this cycle |
| wrCondMode | input | 1 | 0: single immediate, 1: conditional choice |
| wrCond | input | COND_W | Condition operand |
| wrImm0 | input | ADDR_W | Immediate used for a single set or a zero condition |
| wrImm1 | input | ADDR_W | Immediate used for a nonzero condition |
| jmpReq | input | 1 | Jump-to-target operation |
| otherJump | input | 1 | Some other jump executed |
| restoreEn | input | 1 | Load saved context |
| restoreTarget | input | ADDR_W | Saved target value |
| restoreValid | input | 1 | Saved validity |
| redirect | output | 1 | Fetch redirect strobe |
| redirectAddr | output | ADDR_W | Redirect address |
| trap | output | 1 | Jump through an invalid target |
| stall | output | 1 | Jump held for an outstanding update |
| saveTarget | output | ADDR_W | Current target value |
| saveValid | output | 1 | Current validity |

## Verification
The conditional set is driven with a zero condition, a small nonzero condition and a condition with only the top bit set. The last case separates a full-width zero test from a test on the low bits only. Jumps are made through a valid target, an invalid target and a target with an update still outstanding. This separates redirect, trap and stall, and shows that the stalled jump picks up the value that was written later and not the stale one. Same-cycle collisions (a write with a jump, and a restore with a write) show which state each operation sees and which one wins.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  typedef struct packed {
    logic loadWrite;
    logic loadRestore;
  } jtuStrobe_t;
endpackage

// File: rtl/jtu_datapath.sv
module jtu_datapath
  import jtu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COND_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  jtuStrobe_t        strobe,
  input  logic              wrCondMode,
  input  logic [COND_W-1:0] wrCond,
  input  logic [ADDR_W-1:0] wrImm0,
  input  logic [ADDR_W-1:0] wrImm1,
  input  logic [ADDR_W-1:0] restoreTarget,
  output logic [ADDR_W-1:0] target
);
  localparam logic [COND_W-1:0] CondZero = '0;

  logic [ADDR_W-1:0] chosenImm;

  always_comb begin
    if (wrCondMode && (wrCond != CondZero)) chosenImm = wrImm1;
    else                                    chosenImm = wrImm0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    target <= '0;
    else if (strobe.loadRestore)  target <= restoreTarget;
    else if (strobe.loadWrite)    target <= chosenImm;
  end
endmodule

// File: rtl/jtu_ctrl.sv
module jtu_ctrl
  import jtu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setIssue,
  input  logic       wrValid,
  input  logic       jmpReq,
  input  logic       otherJump,
  input  logic       restoreEn,
  input  logic       restoreValid,
  output jtuStrobe_t strobe,
  output logic       redirect,
  output logic       trap,
  output logic       stall,
  output logic       validFlag
);
  logic pendingFlag;
  logic jumpDone;

  always_comb begin
    stall    = jmpReq && pendingFlag;
    redirect = jmpReq && !pendingFlag && validFlag;
    trap     = jmpReq && !pendingFlag && !validFlag;
    jumpDone = redirect || trap || otherJump;
    strobe.loadRestore = restoreEn;
    strobe.loadWrite   = wrValid && !restoreEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validFlag   <= 1'b0;
      pendingFlag <= 1'b0;
    end else begin
      if (restoreEn)      validFlag <= restoreValid;
      else if (jumpDone)  validFlag <= 1'b0;
      else if (wrValid)   validFlag <= 1'b1;

      if (setIssue)                  pendingFlag <= 1'b1;
      else if (restoreEn || wrValid) pendingFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COND_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setIssue,
  input  logic              wrValid,
  input  logic              wrCondMode,
  input  logic [COND_W-1:0] wrCond,
  input  logic [ADDR_W-1:0] wrImm0,
  input  logic [ADDR_W-1:0] wrImm1,
  input  logic              jmpReq,
  input  logic              otherJump,
  input  logic              restoreEn,
  input  logic [ADDR_W-1:0] restoreTarget,
  input  logic              restoreValid,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              trap,
  output logic              stall,
  output logic [ADDR_W-1:0] saveTarget,
  output logic              saveValid
);
  jtuStrobe_t        strobe;
  logic [ADDR_W-1:0] target;

  jtu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .setIssue(setIssue), .wrValid(wrValid),
    .jmpReq(jmpReq), .otherJump(otherJump), .restoreEn(restoreEn),
    .restoreValid(restoreValid), .strobe(strobe), .redirect(redirect),
    .trap(trap), .stall(stall), .validFlag(saveValid)
  );

  jtu_datapath #(.ADDR_W(ADDR_W), .COND_W(COND_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCondMode(wrCondMode),
    .wrCond(wrCond), .wrImm0(wrImm0), .wrImm1(wrImm1),
    .restoreTarget(restoreTarget), .target(target)
  );

  assign redirectAddr = target;
  assign saveTarget   = target;
endmodule

// File: rtl/jtu_checker.sv
module jtu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              jmpReq,
  input logic              otherJump,
  input logic              restoreEn,
  input logic              redirect,
  input logic              trap,
  input logic              stall,
  input logic [ADDR_W-1:0] redirectAddr,
  input logic [ADDR_W-1:0] saveTarget,
  input logic              saveValid
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $countones({redirect, trap, stall}) <= 1); // R9

  AST_TRAP_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (jmpReq && !stall && !saveValid) |-> (trap && !redirect)); // R5

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (saveValid && redirectAddr == saveTarget)); // R4

  AST_JUMP_INVALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    ((redirect || trap || otherJump) && !restoreEn) |=> !saveValid); // R6

  AST_WRITE_VALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !restoreEn && !redirect && !trap && !otherJump) |=> saveValid); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !wrValid && !restoreEn && !otherJump) |=>
      ($stable(saveTarget) && $stable(saveValid))); // R7
endmodule

bind jump_target_unit jtu_checker #(.ADDR_W(ADDR_W)) i_jtu_checker (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .jmpReq(jmpReq),
  .otherJump(otherJump), .restoreEn(restoreEn), .redirect(redirect),
  .trap(trap), .stall(stall), .redirectAddr(redirectAddr),
  .saveTarget(saveTarget), .saveValid(saveValid)
);

// File: tb/test_jump_target_unit.sv
module test_jump_target_unit;
  localparam int AW = 32;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic setIssue, wrValid, wrCondMode, jmpReq, otherJump, restoreEn, restoreValid;
  logic [CW-1:0] wrCond;
  logic [AW-1:0] wrImm0, wrImm1, restoreTarget;
  logic redirect, trap, stall, saveValid;
  logic [AW-1:0] redirectAddr, saveTarget;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  jump_target_unit #(.ADDR_W(AW), .COND_W(CW)) i_jump_target_unit (
    .clk(clk), .rstN(rstN), .setIssue(setIssue), .wrValid(wrValid),
    .wrCondMode(wrCondMode), .wrCond(wrCond), .wrImm0(wrImm0), .wrImm1(wrImm1),
    .jmpReq(jmpReq), .otherJump(otherJump), .restoreEn(restoreEn),
    .restoreTarget(restoreTarget), .restoreValid(restoreValid),
    .redirect(redirect), .redirectAddr(redirectAddr), .trap(trap), .stall(stall),
    .saveTarget(saveTarget), .saveValid(saveValid)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    setIssue = 0; wrValid = 0; wrCondMode = 0; wrCond = '0; wrImm0 = '0; wrImm1 = '0;
    jmpReq = 0; otherJump = 0; restoreEn = 0; restoreTarget = '0; restoreValid = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic checkOutcome(input string req, input logic r, input logic t, input logic s);
    check(req, {29'b0, redirect, trap, stall}, {29'b0, r, t, s});
    check("R9", $countones({redirect, trap, stall}) <= 1, 1);
  endtask

  task automatic writeSet(input logic mode, input logic [CW-1:0] c,
                          input logic [AW-1:0] a, input logic [AW-1:0] b);
    wrValid = 1; wrCondMode = mode; wrCond = c; wrImm0 = a; wrImm1 = b;
    tick();
  endtask

  task automatic testReset();
    check("R1 valid", saveValid, 0);
    checkOutcome("R1 outputs", 0, 0, 0);
  endtask

  task automatic testSingleSetAndJump();
    writeSet(0, 32'h1, 32'h0000_1000, 32'h0000_2000);
    check("R2 target", saveTarget, 32'h0000_1000);
    check("R2 valid", saveValid, 1);
    jmpReq = 1; #1;
    checkOutcome("R4 redirect", 1, 0, 0);
    check("R4 addr", redirectAddr, 32'h0000_1000);
    tick();
    check("R4 invalid after", saveValid, 0);
    checkOutcome("R4 one pulse", 0, 0, 0);
    jmpReq = 1; #1;
    checkOutcome("R5 trap", 0, 1, 0);
    tick();
  endtask

  task automatic testConditional();
    writeSet(1, 32'h0, 32'hAAAA_0000, 32'hBBBB_0000);
    check("R3 zero cond", saveTarget, 32'hAAAA_0000);
    check("R3 valid", saveValid, 1);
    writeSet(1, 32'h5, 32'hAAAA_0004, 32'hBBBB_0004);
    check("R3 nonzero cond", saveTarget, 32'hBBBB_0004);
    writeSet(1, 32'h8000_0000, 32'hAAAA_0008, 32'hBBBB_0008);
    check("R3 top bit cond", saveTarget, 32'hBBBB_0008);
  endtask

  task automatic testOtherJump();
    writeSet(0, '0, 32'h0000_3000, '0);
    otherJump = 1;
    tick();
    check("R6 other jump invalidates", saveValid, 0);
    jmpReq = 1; #1;
    checkOutcome("R6 then trap", 0, 1, 0);
    tick();
  endtask

  task automatic testPending();
    writeSet(0, '0, 32'h0000_4000, '0);
    setIssue = 1;
    tick();
    jmpReq = 1; #1;
    checkOutcome("R7 stall", 1'b0, 1'b0, 1'b1);
    tick();
    jmpReq = 1; #1;
    checkOutcome("R7 still stall", 0, 0, 1);
    check("R7 held valid", saveValid, 1);
    check("R7 held target", saveTarget, 32'h0000_4000);
    jmpReq = 1; wrValid = 1; wrImm0 = 32'h0000_5000; #1;
    checkOutcome("R7 stall on landing", 0, 0, 1);
    tick();
    jmpReq = 1; #1;
    checkOutcome("R7 released", 1, 0, 0);
    check("R7 new addr", redirectAddr, 32'h0000_5000);
    tick();
  endtask

  task automatic testSaveRestore();
    restoreEn = 1; restoreTarget = 32'hCAFE_0000; restoreValid = 1;
    tick();
    check("R8 restored target", saveTarget, 32'hCAFE_0000);
    check("R8 restored valid", saveValid, 1);
    restoreEn = 1; restoreTarget = 32'hCAFE_0010; restoreValid = 0;
    tick();
    check("R8 restored invalid", saveValid, 0);
    jmpReq = 1; #1;
    checkOutcome("R8 trap after invalid restore", 0, 1, 0);
    tick();
  endtask

  task automatic testCollision();
    writeSet(0, '0, 32'h0000_6000, '0);
    jmpReq = 1; wrValid = 1; wrImm0 = 32'h0000_7000; #1;
    checkOutcome("R10 redirect", 1, 0, 0);
    check("R10 old addr", redirectAddr, 32'h0000_6000);
    tick();
    check("R10 valid cleared", saveValid, 0);
    check("R10 new value stored", saveTarget, 32'h0000_7000);
  endtask

  task automatic testRestorePriority();
    wrValid = 1; wrImm0 = 32'h0000_8000;
    restoreEn = 1; restoreTarget = 32'h0000_9000; restoreValid = 1;
    tick();
    check("R11 restore wins", saveTarget, 32'h0000_9000);
    setIssue = 1;
    tick();
    restoreEn = 1; restoreTarget = 32'h0000_A000; restoreValid = 1;
    tick();
    jmpReq = 1; #1;
    checkOutcome("R11 pending cleared", 1, 0, 0);
    check("R11 addr", redirectAddr, 32'h0000_A000);
    tick();
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    testReset();
    testSingleSetAndJump();
    testConditional();
    testOtherJump();
    testPending();
    testSaveRestore();
    testCollision();
    testRestorePriority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule